// File: doc/BRIEF.md
# Matrix remap index generator

This block turns the plain element counter of a vector loop into a reshaped element offset. The offset follows a 1D, 2D or 3D matrix schedule. The schedule is set by three dimension fields (x, y and z, each holding size minus one) and a 3-bit nesting code. The code picks which axis is the innermost loop, which is the middle loop and which is the outermost loop. The offset for digits (x, y, z) is `x + (xd+1)*y + (xd+1)*(yd+1)*z`. The linear index is first wrapped modulo the schedule size `(xd+1)*(yd+1)*(zd+1)`. The offset is then reduced modulo a maximum vector length. Sizes need not be powers of two. A schedule smaller than the vector length simply repeats.

A start pulse loads any element index, so a loop that was interrupted can resume where it stopped. The block recomputes the axis digits for that index using a shared sequential restoring divider, with a fixed cycle cost. Each later step pulse advances the digits with counters. One divider pass then reduces the new offset. Four instances side by side give four independently remapped operands. The configuration inputs must stay stable while a sequence runs.

The state machine has these states and transitions:
- IDLE waits for a start pulse.
- WRAP reduces the start index modulo the schedule size.
- SPLIT_IN extracts the innermost digit.
- SPLIT_MID extracts the middle and outer digits and loads the counters.
- CALC reduces the offset modulo MAXVL.
- READY presents the offset. In READY, a step pulse goes to CALC, or to IDLE when done is high. A start pulse in any state goes to WRAP.
- Each state from WRAP to CALC leaves on the divider's finish pulse.

Top module: `mtx_remap_gen`

## Requirements
- R1: After reset, ready_o and done_o are 0 and offset_o is 0.
- R2: The offset is `(x + (xd+1)*y + (xd+1)*(yd+1)*z) mod MAXVL`. The digits come from nesting code `cfg_perm_i` as follows, listed as inner, middle, outer:
  - 000: x, y, z
  - 001: x, z, y
  - 010: y, x, z
  - 011: y, z, x
  - 100: z, x, y
  - 101: z, y, x
  
  A start at index 0 gives offset 0.
- R3: Linear index i uses position `i mod ((xd+1)*(yd+1)*(zd+1))`. A 4-by-1 shape with code 000 therefore gives 0,1,2,3 repeating over 16 steps.
- R4: The offset is always reduced modulo `cfg_maxvl_i` (at least 1), so offsets can repeat. A 4x4 shape with code 010 and MAXVL 4 gives 0,0,0,0,1,1,1,1,...
- R5: Code 000, and the unused codes 110 and 111, give the unchanged linear order i mod schedule size.
- R6: When at least two of the three sizes are one, the output equals the linear index for every nesting code.
- R7: Non-power-of-two sizes work directly. A 3-by-4 shape with code 010 gives 0,3,6,9,1,4,7,10,2,5,8,11.
- R8: A start with index i yields the same offset as reaching i by stepping from 0, and stepping continues correctly from there.
- R9: done_o is 1 exactly while the offset for linear index `cfg_vl_i-1` is shown. A step while done_o is 1 returns the block to IDLE with ready_o at 0.
- R10: With `W = max(IW, 3*DW+1)`, ready_o rises `4*(W+2)` cycles after the clock edge that takes a start, and `W+2` cycles after the edge that takes a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence at start_idx_i |
| start_idx_i | input | IW | Linear index to start or resume from |
| step_i | input | 1 | Advance to the next linear index (taken in READY) |
| cfg_xdim_i | input | DW | x size minus one |
| cfg_ydim_i | input | DW | y size minus one |
| cfg_zdim_i | input | DW | z size minus one |
| cfg_perm_i | input | 3 | Loop nesting code |
| cfg_maxvl_i | input | IW | Modulus applied to every offset |
| cfg_vl_i | input | IW | Vector length (at least 1) |
| ready_o | output | 1 | offset_o is valid |
| done_o | output | 1 | Current offset is for the last linear index |
| offset_o | output | IW | Remapped element offset |

## Verification
On every cycle the assertions check several behaviours:
- A valid offset lies below MAXVL.
- Every axis digit stays within its size while an offset is shown.
- The divider remainder stays below its divisor.
- An accepted step advances the linear index by exactly one.
- A step taken at done, or any start, drops ready.

The exact offset sequences can only be shown by the bench's sweeps, which compare against an arithmetic model. These sweeps cover each nesting code, wrapping, MAXVL reduction, degenerate and non-power-of-two shapes, and resume from every index. The bench also measures the fixed latencies and checks the placement of done.

// File: rtl/mtx_remap_pkg.sv
package mtx_remap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRAP,
        ST_SPLIT_IN,
        ST_SPLIT_MID,
        ST_CALC,
        ST_READY
    } gen_state_t;

    // axis numbers: 0 = x, 1 = y, 2 = z
    typedef struct packed {
        logic [1:0] inner;
        logic [1:0] mid;
        logic [1:0] outer;
    } nest_t;

    function automatic nest_t decode_nest(input logic [2:0] code);
        nest_t n;
        case (code)
            3'd1:    n = '{inner: 2'd0, mid: 2'd2, outer: 2'd1};
            3'd2:    n = '{inner: 2'd1, mid: 2'd0, outer: 2'd2};
            3'd3:    n = '{inner: 2'd1, mid: 2'd2, outer: 2'd0};
            3'd4:    n = '{inner: 2'd2, mid: 2'd0, outer: 2'd1};
            3'd5:    n = '{inner: 2'd2, mid: 2'd1, outer: 2'd0};
            default: n = '{inner: 2'd0, mid: 2'd1, outer: 2'd2};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mtx_remap_div.sv
module mtx_remap_div #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    sh, diff;
    logic          take;

    assign sh   = {r_r, q_r[W-1]};
    assign diff = sh - {1'b0, d_r};
    assign take = (sh >= {1'b0, d_r});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else if (go) begin
            q_r <= dvd;
            r_r <= '0;
            d_r <= dvs;
            cnt <= CW'(W);
            run <= 1'b1;
            fin <= 1'b0;
        end else if (run) begin
            r_r <= take ? diff[W-1:0] : sh[W-1:0];
            q_r <= {q_r[W-2:0], take};
            cnt <= cnt - 1'b1;
            run <= (cnt != CW'(1));
            fin <= (cnt == CW'(1));
        end else begin
            fin <= 1'b0;
        end
    end

    assign quo = q_r;
    assign rem = r_r;

    // R4: the remainder handed back is always below a nonzero divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && d_r != '0) |-> (r_r < d_r));

endmodule

// File: rtl/mtx_remap_ctr.sv
module mtx_remap_ctr
    import mtx_remap_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic [2:0][DW-1:0] ld_dig,
    input  logic [2:0][DW-1:0] lim,
    input  nest_t              nest,
    output logic [2:0][DW-1:0] dig
);
    logic [2:0]          at_max;
    logic [2:0][DW-1:0]  nxt;

    for (genvar a = 0; a < 3; a++) begin : g_axis
        assign at_max[a] = (dig[a] == lim[a]);
    end

    always_comb begin
        nxt = dig;
        if (!at_max[nest.inner]) begin
            nxt[nest.inner] = dig[nest.inner] + 1'b1;
        end else begin
            nxt[nest.inner] = '0;
            if (!at_max[nest.mid]) begin
                nxt[nest.mid] = dig[nest.mid] + 1'b1;
            end else begin
                nxt[nest.mid] = '0;
                if (!at_max[nest.outer]) begin
                    nxt[nest.outer] = dig[nest.outer] + 1'b1;
                end else begin
                    nxt[nest.outer] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig <= '0;
        end else if (load) begin
            dig <= ld_dig;
        end else if (adv) begin
            dig <= nxt;
        end
    end

endmodule

// File: rtl/mtx_remap_gen.sv
module mtx_remap_gen
    import mtx_remap_pkg::*;
#(
    parameter int DW = 4,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [IW-1:0] start_idx_i,
    input  logic          step_i,
    input  logic [DW-1:0] cfg_xdim_i,
    input  logic [DW-1:0] cfg_ydim_i,
    input  logic [DW-1:0] cfg_zdim_i,
    input  logic [2:0]    cfg_perm_i,
    input  logic [IW-1:0] cfg_maxvl_i,
    input  logic [IW-1:0] cfg_vl_i,
    output logic          ready_o,
    output logic          done_o,
    output logic [IW-1:0] offset_o
);
    localparam int W = (IW > 3 * DW + 1) ? IW : 3 * DW + 1;

    gen_state_t         st, st_nxt;
    logic [IW-1:0]      li, off;
    logic [W-1:0]       rr, qq;
    logic [DW-1:0]      din;
    logic               div_go, div_fin;
    logic [W-1:0]       div_quo, div_rem, dvd, dvs;
    nest_t              nest;
    logic [2:0][DW-1:0] lim, dig, ld_dig;
    logic [W-1:0]       sz_x, sz_y, sz_z, sz_in, sz_mid, sz_out, sched, raw;
    logic               ctr_ld, ctr_adv;

    assign nest   = decode_nest(cfg_perm_i);
    assign lim    = {cfg_zdim_i, cfg_ydim_i, cfg_xdim_i};
    assign sz_x   = W'(cfg_xdim_i) + W'(1);
    assign sz_y   = W'(cfg_ydim_i) + W'(1);
    assign sz_z   = W'(cfg_zdim_i) + W'(1);
    assign sz_in  = W'(lim[nest.inner]) + W'(1);
    assign sz_mid = W'(lim[nest.mid]) + W'(1);
    assign sz_out = W'(lim[nest.outer]) + W'(1);
    assign sched  = sz_x * sz_y * sz_z;
    assign raw    = W'(dig[0]) + sz_x * W'(dig[1]) + sz_x * sz_y * W'(dig[2]);

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:      st_nxt = ST_IDLE;
            ST_WRAP:      if (div_fin) st_nxt = ST_SPLIT_IN;
            ST_SPLIT_IN:  if (div_fin) st_nxt = ST_SPLIT_MID;
            ST_SPLIT_MID: if (div_fin) st_nxt = ST_CALC;
            ST_CALC:      if (div_fin) st_nxt = ST_READY;
            ST_READY:     if (step_i)  st_nxt = done_o ? ST_IDLE : ST_CALC;
            default:      st_nxt = ST_IDLE;
        endcase
        if (start_i) st_nxt = ST_WRAP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            div_go <= 1'b0;
        end else begin
            st     <= st_nxt;
            div_go <= start_i ||
                      ((st_nxt != st) && (st_nxt != ST_IDLE) && (st_nxt != ST_READY));
        end
    end

    // divider operand selection per state
    always_comb begin
        unique case (st)
            ST_WRAP:      begin dvd = W'(li); dvs = sched;  end
            ST_SPLIT_IN:  begin dvd = rr;     dvs = sz_in;  end
            ST_SPLIT_MID: begin dvd = qq;     dvs = sz_mid; end
            default:      begin dvd = raw;    dvs = W'(cfg_maxvl_i); end
        endcase
    end

    mtx_remap_div #(.W(W)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .dvd  (dvd),
        .dvs  (dvs),
        .quo  (div_quo),
        .rem  (div_rem),
        .fin  (div_fin)
    );

    always_comb begin
        ld_dig              = '0;
        ld_dig[nest.inner]  = din;
        ld_dig[nest.mid]    = div_rem[DW-1:0];
        ld_dig[nest.outer]  = div_quo[DW-1:0];
    end

    assign ctr_ld  = (st == ST_SPLIT_MID) && div_fin && !start_i;
    assign ctr_adv = (st == ST_READY) && step_i && !done_o && !start_i;

    mtx_remap_ctr #(.DW(DW)) i_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctr_ld),
        .adv   (ctr_adv),
        .ld_dig(ld_dig),
        .lim   (lim),
        .nest  (nest),
        .dig   (dig)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            li  <= '0;
            rr  <= '0;
            qq  <= '0;
            din <= '0;
            off <= '0;
        end else if (start_i) begin
            li <= start_idx_i;
        end else begin
            if (st == ST_WRAP && div_fin) rr <= div_rem;
            if (st == ST_SPLIT_IN && div_fin) begin
                din <= div_rem[DW-1:0];
                qq  <= div_quo;
            end
            if (st == ST_CALC && div_fin) off <= div_rem[IW-1:0];
            if (ctr_adv) li <= li + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready_o  = (st == ST_READY);
        done_o   = (st == ST_READY) && (li == cfg_vl_i - 1'b1);
        offset_o = off;
    end

    // R4: every presented offset is below MAXVL
    a_r4_offset_below_maxvl: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && cfg_maxvl_i != '0) |-> (offset_o < cfg_maxvl_i));

    // R8: digits recovered on resume fit their axes
    a_r8_inner_digit_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPLIT_IN && div_fin) |-> (div_rem < sz_in));
    a_r8_outer_digit_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPLIT_MID && div_fin) |-> (div_rem < sz_mid && div_quo < sz_out));

    // R3: the schedule position stays inside the shape while shown
    a_r3_digits_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (dig[0] <= lim[0] && dig[1] <= lim[1] && dig[2] <= lim[2]));

    // R9: an accepted step moves the linear index by one
    a_r9_step_advances_index: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && step_i && !done_o && !start_i) |=> (li == $past(li) + 1'b1));

    // R9: stepping past the last element leaves READY
    a_r9_done_step_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && step_i) |=> !ready_o);

    // R10: a start always withdraws the current offset
    a_r10_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ready_o);

endmodule

// File: tb/test_mtx_remap_gen.sv
module test_mtx_remap_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 4;
    localparam int IW    = 8;
    localparam int W     = (IW > 3 * DW + 1) ? IW : 3 * DW + 1;
    localparam int LSTEP = W + 2;
    localparam int LRES  = 4 * (W + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [IW-1:0] start_idx_i = '0;
    logic          step_i = 1'b0;
    logic [DW-1:0] cfg_xdim_i = '0, cfg_ydim_i = '0, cfg_zdim_i = '0;
    logic [2:0]    cfg_perm_i = '0;
    logic [IW-1:0] cfg_maxvl_i = IW'(16), cfg_vl_i = IW'(1);
    logic          ready_o, done_o;
    logic [IW-1:0] offset_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mtx_remap_gen #(.DW(DW), .IW(IW)) i_mtx_remap_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_idx_i(start_idx_i),
        .step_i(step_i), .cfg_xdim_i(cfg_xdim_i), .cfg_ydim_i(cfg_ydim_i),
        .cfg_zdim_i(cfg_zdim_i), .cfg_perm_i(cfg_perm_i), .cfg_maxvl_i(cfg_maxvl_i),
        .cfg_vl_i(cfg_vl_i), .ready_o(ready_o), .done_o(done_o), .offset_o(offset_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // arithmetic model of the schedule
    function automatic int model(input int i, input int xd, input int yd, input int zd,
                                 input int pm, input int mv);
        int sz[3];
        int d[3];
        int ai, am, ao, s, r, q;
        sz[0] = xd + 1; sz[1] = yd + 1; sz[2] = zd + 1;
        case (pm)
            1: begin ai = 0; am = 2; ao = 1; end
            2: begin ai = 1; am = 0; ao = 2; end
            3: begin ai = 1; am = 2; ao = 0; end
            4: begin ai = 2; am = 0; ao = 1; end
            5: begin ai = 2; am = 1; ao = 0; end
            default: begin ai = 0; am = 1; ao = 2; end
        endcase
        s = sz[0] * sz[1] * sz[2];
        r = i % s;
        d[ai] = r % sz[ai];
        q = r / sz[ai];
        d[am] = q % sz[am];
        d[ao] = q / sz[am];
        return (d[0] + sz[0] * d[1] + sz[0] * sz[1] * d[2]) % mv;
    endfunction

    // literal expectations written straight from the requirement examples
    function automatic int literal(input int kind, input int i, input int s);
        case (kind)
            1: return i % s;
            2: return (i % 4) * 3 + (i / 4);
            3: return i / 4;
            4: return i % 4;
            default: return 0;
        endcase
    endfunction

    task automatic run_seq(input int xd, input int yd, input int zd, input int pm,
                           input int mv, input int vl, input int sidx, input int kind,
                           input string tag);
        int cnt, e;
        @(negedge clk);
        cfg_xdim_i  = DW'(xd);
        cfg_ydim_i  = DW'(yd);
        cfg_zdim_i  = DW'(zd);
        cfg_perm_i  = 3'(pm);
        cfg_maxvl_i = IW'(mv);
        cfg_vl_i    = IW'(vl);
        start_idx_i = IW'(sidx);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!ready_o && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LRES + 1, "R10 start latency", cnt - 1, LRES);
        for (int i = sidx; i < vl; i++) begin
            e = model(i, xd, yd, zd, pm, mv);
            chk(offset_o == IW'(e), tag, int'(offset_o), e);
            if (kind != 0) begin
                e = literal(kind, i, (xd + 1) * (yd + 1) * (zd + 1));
                chk(offset_o == IW'(e), tag, int'(offset_o), e);
            end
            chk(done_o == (i == vl - 1), "R9 done", int'(done_o), int'(i == vl - 1));
            step_i = 1'b1;
            @(negedge clk);
            step_i = 1'b0;
            cnt = 1;
            if (i < vl - 1) begin
                while (!ready_o && cnt < 400) begin
                    @(negedge clk);
                    cnt++;
                end
                chk(cnt == LSTEP + 1, "R10 step latency", cnt - 1, LSTEP);
            end else begin
                chk(ready_o == 1'b0, "R9 idle after last step", int'(ready_o), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready_o == 1'b0, "R1 ready", int'(ready_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(offset_o == '0, "R1 offset", int'(offset_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o == 1'b0, "R1 ready after release", int'(ready_o), 0);

        // R4: 4x4 with y innermost, modulus 4
        run_seq(3, 3, 0, 2, 4, 16, 0, 3, "R4");
        // R3: 4-by-1 repeats
        run_seq(3, 0, 0, 0, 16, 16, 0, 4, "R3");
        // R7: 3-by-4 transpose
        run_seq(2, 3, 0, 2, 16, 12, 0, 2, "R7");
        // R2 / R5: all nesting codes on a 2x3x2 shape, wrapping past 12
        for (int p = 0; p < 8; p++) begin
            if (p == 0 || p > 5) run_seq(1, 2, 1, p, 16, 15, 0, 1, "R5");
            else                 run_seq(1, 2, 1, p, 16, 15, 0, 0, "R2");
        end
        // R6: two axes of size one give the linear order
        for (int p = 0; p < 6; p++) begin
            run_seq(0, 4, 0, p, 16, 5, 0, 1, "R6");
            run_seq(0, 0, 4, p, 16, 5, 0, 1, "R6");
            run_seq(4, 0, 0, p, 16, 5, 0, 1, "R6");
        end
        // R4: 3D schedule reduced by a small modulus
        run_seq(1, 2, 1, 3, 5, 12, 0, 0, "R4");
        // R8: resume from every index
        for (int s = 0; s < 15; s++) begin
            run_seq(1, 2, 1, 1, 16, 15, s, 0, "R8");
            run_seq(1, 2, 1, 4, 16, 15, s, 0, "R8");
        end
        for (int s = 0; s < 12; s++) begin
            run_seq(2, 3, 0, 2, 7, 12, s, 0, "R8");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule